// File: doc/BRIEF.md
# Lookahead Head-Cache Refill Arbiter

This block decides which of several FIFO head caches gets refilled from bulk memory. Read requests arrive at one per timeslot, each naming a queue. They do not go to the cache at once. They first pass through a fixed-depth lookahead pipeline. While they wait, the arbiter can see every pending request. Once every `B` timeslots it picks the queue whose cached bytes will run out first and issues a `B`-byte refill for that queue. Each request comes out of the far end of the pipeline in arrival order and is granted from the cache at that point.

The pipeline is `NQ*(B-1)+1` slots deep. Each slot holds a valid bit and a queue index. A per-queue occupancy counter tracks the cached bytes: a refill adds `B` and a grant takes away one. A queue is critical when the number of its pending requests, counted from the output end up to some slot, is greater than its occupancy. The refill goes to the queue whose critical slot lies nearest the output end. If no queue is critical, the refill slot stays idle.

The memory timing and the packet data are handled elsewhere. This block produces only the refill command, the delayed grant and a flag that reports a grant taken from an empty cache.

Top module: `ecq_refill_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `grant_valid`, `repl_valid` and `underflow` are 0. Reset clears every pipeline slot and sets every queue occupancy to 0.
- R2: A request presented at a rising edge with `req_valid`=1 appears on `grant_valid`/`grant_queue` exactly `NQ*(B-1)+1` edges later, with the same queue index. Requests come out in arrival order.
- R3: `repl_valid` can be 1 only in the cycle after every `B`-th rising edge counted from reset release (edges B, 2B, 3B, ...). It is never 1 in two consecutive cycles.
- R4: At a refill edge, the target is the queue of the valid pipeline slot nearest the output end at which that queue's count of valid requests, from the output end up to and including that slot, exceeds the queue's occupancy. Slot 0 is the input end and slot `NQ*(B-1)` is the output end.
- R5: If no queue is critical at a refill edge, `repl_valid` stays 0. In particular, it stays 0 when the pipeline is empty.
- R6: At each edge, a queue's occupancy increases by `B` if it is refilled and decreases by 1 if its request leaves the pipeline; both changes apply at the same edge. If a leaving request finds occupancy 0 after the same-edge refill, `underflow` is 1 for one cycle alongside that grant, and the occupancy stays 0.
- R7: A request with `req_valid`=0 occupies a slot but is not counted in any criticality test, produces no grant and changes no occupancy, whatever `req_queue` holds.
- R8: Requests may arrive at every edge without stalls. Back-to-back requests produce back-to-back grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timeslot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A read request is present this timeslot |
| req_queue | input | $clog2(NQ) | Queue index of the request |
| grant_valid | output | 1 | A request leaves the pipeline and is served from the cache |
| grant_queue | output | $clog2(NQ) | Queue index of the granted request |
| repl_valid | output | 1 | A B-byte refill is issued |
| repl_queue | output | $clog2(NQ) | Queue that receives the refill |
| underflow | output | 1 | The granted queue had no cached byte |

## Verification
Some properties are checked on every cycle. These are: the one-cycle spacing of refills, the fact that the pipeline tail becomes the grant at the next edge, that an underflow comes only with a grant, that an empty pipeline never triggers a refill, and that a refilled queue holds at least `B-1` bytes afterwards. Other behaviours are shown only by the bench. It compares the choice of the earliest critical queue across many request mixes, the exact grant latency, and the refill phase relative to reset. It also compares the underflow timing against an arithmetic occupancy model, covering per-queue bursts, all queue-pair alternations, invalid slots, an idle drain, a mid-stream reset and a long pseudo-random stream.

// File: rtl/ecq_refill_arbiter.sv
module ecq_refill_arbiter #(
  parameter int NQ = 4,
  parameter int B  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [$clog2(NQ)-1:0] req_queue,
  output logic                  grant_valid,
  output logic [$clog2(NQ)-1:0] grant_queue,
  output logic                  repl_valid,
  output logic [$clog2(NQ)-1:0] repl_queue,
  output logic                  underflow
);
  localparam int QW    = $clog2(NQ);
  localparam int DEPTH = NQ * (B - 1) + 1;
  localparam int OCCW  = $clog2(DEPTH + B + 1);
  localparam int SW    = $clog2(B);

  logic [DEPTH-1:0] pv;
  logic [QW-1:0]    pq [DEPTH];
  logic [OCCW-1:0]  occ [NQ];
  logic [OCCW-1:0]  occ_nx [NQ];
  logic [SW-1:0]    slot;
  logic             scan_go;
  logic             hit;
  logic [QW-1:0]    pick;
  logic             uf_nx;

  wire tail_v = pv[DEPTH-1];
  wire [QW-1:0] tail_q = pq[DEPTH-1];

  assign scan_go = (slot == SW'(B - 1));

  always_comb begin
    logic [OCCW-1:0] cnt;
    hit  = 1'b0;
    pick = '0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt = '0;
      for (int j = i; j < DEPTH; j++)
        if (pv[j] && pq[j] == pq[i]) cnt = cnt + OCCW'(1);
      if (pv[i] && cnt > occ[pq[i]]) begin
        hit  = 1'b1;
        pick = pq[i];
      end
    end
  end

  always_comb begin
    logic [OCCW-1:0] sum;
    uf_nx = 1'b0;
    for (int q = 0; q < NQ; q++) begin
      sum = occ[q] + ((scan_go && hit && pick == QW'(q)) ? OCCW'(B) : '0);
      occ_nx[q] = sum;
      if (tail_v && tail_q == QW'(q)) begin
        if (sum == '0) uf_nx = 1'b1;
        else occ_nx[q] = sum - OCCW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv          <= '0;
      slot        <= '0;
      grant_valid <= 1'b0;
      grant_queue <= '0;
      repl_valid  <= 1'b0;
      repl_queue  <= '0;
      underflow   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) pq[i] <= '0;
      for (int q = 0; q < NQ; q++) occ[q] <= '0;
    end else begin
      pv    <= {pv[DEPTH-2:0], req_valid};
      pq[0] <= req_queue;
      for (int i = 1; i < DEPTH; i++) pq[i] <= pq[i-1];
      slot        <= scan_go ? '0 : slot + SW'(1);
      grant_valid <= tail_v;
      grant_queue <= tail_q;
      repl_valid  <= scan_go && hit;
      repl_queue  <= pick;
      underflow   <= uf_nx;
      for (int q = 0; q < NQ; q++) occ[q] <= occ_nx[q];
    end
  end

  p_idle_in_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !grant_valid && !repl_valid && !underflow);

  p_tail_becomes_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tail_v |=> grant_valid && grant_queue == $past(tail_q));

  p_repl_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    repl_valid |=> !repl_valid);

  p_refill_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    repl_valid |-> occ[repl_queue] >= OCCW'(B - 1));

  p_no_repl_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pv == '0) |=> !repl_valid);

  p_underflow_with_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> grant_valid);
endmodule

// File: tb/ecq_refill_arbiter_test.sv
module ecq_refill_arbiter_test;
  localparam int NQ    = 4;
  localparam int B     = 4;
  localparam int QW    = $clog2(NQ);
  localparam int DEPTH = NQ * (B - 1) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [QW-1:0] req_queue = '0;
  logic grant_valid, repl_valid, underflow;
  logic [QW-1:0] grant_queue, repl_queue;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  bit mv [DEPTH];
  int mq [DEPTH];
  int mocc [NQ];
  int mslot;
  bit e_gv, e_rv, e_uf;
  int e_gq, e_rq;
  logic [15:0] lfsr = 16'hACE1;

  ecq_refill_arbiter #(.NQ(NQ), .B(B)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_queue(req_queue),
    .grant_valid(grant_valid), .grant_queue(grant_queue),
    .repl_valid(repl_valid), .repl_queue(repl_queue), .underflow(underflow)
  );

  always #10 clk = ~clk;

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; mq[i] = 0; end
    for (int q = 0; q < NQ; q++) mocc[q] = 0;
    mslot = 0;
  endtask

  task automatic model_step(input bit v, input int q);
    bit hit = 0;
    int pick = 0;
    e_gv = mv[DEPTH-1];
    e_gq = mq[DEPTH-1];
    if (mslot == B - 1) begin
      for (int i = DEPTH - 1; i >= 0 && !hit; i--) begin
        int c = 0;
        if (mv[i]) begin
          for (int j = DEPTH - 1; j >= i; j--) if (mv[j] && mq[j] == mq[i]) c++;
          if (c > mocc[mq[i]]) begin hit = 1; pick = mq[i]; end
        end
      end
    end
    e_rv = hit;
    if (hit) e_rq = pick;
    if (hit) mocc[pick] += B;
    e_uf = 0;
    if (e_gv) begin
      if (mocc[e_gq] == 0) e_uf = 1;
      else mocc[e_gq]--;
    end
    for (int i = DEPTH - 1; i > 0; i--) begin mv[i] = mv[i-1]; mq[i] = mq[i-1]; end
    mv[0] = v;
    mq[0] = q;
    mslot = (mslot == B - 1) ? 0 : mslot + 1;
  endtask

  task automatic step(input bit v, input int q);
    int prev_rq = e_rq;
    req_valid = v;
    req_queue = QW'(q);
    model_step(v, q);
    if (!e_rv) e_rq = prev_rq;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (grant_valid !== e_gv || (e_gv && grant_queue !== QW'(e_gq))) begin
      fails++;
      $display("FAIL R2 [%s]: grant actual %0b/%0d expected %0b/%0d",
               phase, grant_valid, grant_queue, e_gv, e_gq);
    end else if (repl_valid !== e_rv || (e_rv && repl_queue !== QW'(e_rq))) begin
      fails++;
      $display("FAIL R4 [%s]: refill actual %0b/%0d expected %0b/%0d",
               phase, repl_valid, repl_queue, e_rv, e_rq);
    end else if (underflow !== e_uf) begin
      fails++;
      $display("FAIL R6 [%s]: underflow actual %0b expected %0b", phase, underflow, e_uf);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b1;
    req_queue = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (grant_valid !== 1'b0 || repl_valid !== 1'b0 || underflow !== 1'b0) begin
      fails++;
      $display("FAIL R1: outputs in reset actual %0b%0b%0b expected 000",
               grant_valid, repl_valid, underflow);
    end
    rst_n = 1'b1;
    model_reset();
    e_rq = 0;
  endtask

  initial begin
    @(negedge clk);
    phase = "R1";
    do_reset();

    phase = "R2 R8 single-queue";
    for (int q = 0; q < NQ; q++)
      for (int n = 0; n < 3 * DEPTH; n++) step(1, q);

    phase = "R4 round-robin";
    for (int n = 0; n < 120; n++) step(1, n % NQ);

    phase = "R5 drain";
    for (int n = 0; n < DEPTH + 3 * B; n++) step(0, 0);

    phase = "R7 invalid slots";
    for (int n = 0; n < 40; n++) step((n % 3) == 0, (n * 3) % NQ);
    for (int n = 0; n < DEPTH + 2 * B; n++) step(0, n % NQ);

    phase = "R4 R6 queue-pair bursts";
    for (int a = 0; a < NQ; a++)
      for (int b2 = 0; b2 < NQ; b2++)
        for (int len = 1; len <= 6; len++)
          for (int n = 0; n < 24; n++) step(1, ((n / len) % 2) ? b2 : a);

    phase = "R1 R3 mid-stream reset";
    for (int n = 0; n < 7; n++) step(1, n % NQ);
    do_reset();
    for (int n = 0; n < 2 * B + 1; n++) step(1, 2);

    phase = "R3 R4 R6 pseudo-random";
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[1:0] != 2'b00, int'(lfsr[5:4]) % NQ);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule